// File: doc/BRIEF.md
# VCO Band Calibration Sequencer

This block picks the coarse band setting of a voltage-controlled oscillator while its phase-locked loop is in calibration mode. As long as the calibration mode input is high, it turns the charge pump off and clamps the loop filter to its mid-supply control voltage. This opens the loop, so the oscillator runs at a frequency set only by the band code. The block then finds the band code by measuring frequency with a counter under the control of a sequencer state machine.

The search is a binary search that starts at the most significant band bit and ends at the least significant one. Each candidate code is applied to the oscillator. The block waits a settling interval, then counts rising edges of a divided oscillator pulse over a window measured in reference-clock ticks. If the count is below the programmed target, the trial bit is kept; otherwise it is dropped. After the last bit the done flag rises. The chosen code then holds until the next accepted start, even after calibration mode is cleared so that the loop can be closed.

Top module: `vco_band_cal`

## Requirements
- R1: After reset, band_o is 0, done_o is 0, lf_clamp_o is 0 and cp_en_o is 1.
- R2: One clock after cal_mode_i is sampled high, lf_clamp_o is 1 and cp_en_o is 0. One clock after cal_mode_i is sampled low, lf_clamp_o is 0 and cp_en_o is 1.
- R3: A start is accepted only when start_i and cal_mode_i are both high and no search is running. One clock after an accepted start, done_o is 0 and band_o holds only its most significant bit (4'b1000 for the default width). A start while cal_mode_i is low, or while a search is running, has no effect.
- R4: Band bits are decided from the most significant down to bit 0. Each trial bit is kept when the measured edge count is below target_i (unsigned compare) and cleared otherwise. For an oscillator whose count rises with the band code, the result is the largest code whose count is below the target.
- R5: After each new trial code, the block waits SETTLE_TICKS ref_tick_i pulses. It then counts edges over WIN_TICKS ref_tick_i pulses. Clock cycles without ref_tick_i make no progress.
- R6: vco_div_i is asynchronous. It passes through a two-flop synchroniser, and each of its rising edges adds one to the measured count. The count saturates at 2^CNT_W-1 and never wraps.
- R7: done_o rises after bit 0 is decided. From then on, done_o and band_o hold until the next accepted start, even if cal_mode_i is cleared.
- R8: If cal_mode_i is low while a search is running, the search stops. On the next clock band_o is 0 and done_o is 0, and done_o stays low until a new start is accepted.
- R9: A target of 0 gives band 0. A target above every count the oscillator can produce gives the all-ones band (15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_mode_i | input | 1 | Calibration mode level; high opens and clamps the loop |
| start_i | input | 1 | Request to begin a band search |
| target_i | input | CNT_W | Target edge count per window |
| ref_tick_i | input | 1 | One-cycle reference tick that paces settling and the window |
| vco_div_i | input | 1 | Divided oscillator pulse, asynchronous |
| band_o | output | BAND_W | Applied oscillator band code |
| done_o | output | 1 | Search finished; band_o is final |
| cp_en_o | output | 1 | Charge pump enable, low during calibration |
| lf_clamp_o | output | 1 | Loop filter clamp to mid-supply, high during calibration |

## Verification
The bench models the oscillator as a phase accumulator whose edge rate is proportional to band+1, which gives a monotone count-versus-band curve. It runs the search with targets placed midway between the counts of neighbouring bands, so that a kept-versus-dropped error on any bit gives a different final code. The two extreme targets, 0 and the maximum, show whether the compare direction and the bit-clearing rule are right. A double-rate oscillator mode pushes the top band past the counter's maximum, which separates a saturating counter from a wrapping one. Aborts, ignored starts, stopped reference ticks and clearing the mode after done are tried in turn, and the clamp outputs and the hold of the result are compared every clock.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_COUNT  = 3'd2,
        ST_DECIDE = 3'd3,
        ST_DONE   = 3'd4
    } vbc_state_e;

    function automatic int vbc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vbc_edge_sync.sv
module vbc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], async_i};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~last_q;

    // R6: an edge pulse is one cycle wide
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R6

endmodule

// File: rtl/vbc_tick_timer.sv
module vbc_tick_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [TMR_W-1:0] limit_i,
    output logic             expire_o
);
    logic [TMR_W-1:0] count_d, count_q;
    logic             last_tick;

    always_comb begin
        last_tick = run_i && tick_i && (count_q == limit_i - 1'b1);
        count_d   = count_q;
        if (clr_i) begin
            count_d = '0;
        end else if (run_i && tick_i) begin
            count_d = last_tick ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign expire_o = last_tick;

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (count_q < limit_i)); // R5

    AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i && !clr_i) |=> $stable(count_q)); // R5

endmodule

// File: rtl/vbc_edge_counter.sv
module vbc_edge_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             pulse_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clr_i) begin
            count_d = '0;
        end else if (en_i && pulse_i && (count_q != CNT_MAX)) begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && count_q == CNT_MAX) |=> (count_q == CNT_MAX)); // R6

    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !en_i) |=> $stable(count_q)); // R6

endmodule

// File: rtl/vbc_seq.sv
module vbc_seq
    import vbc_pkg::*;
#(
    parameter int BAND_W = 4,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_mode_i,
    input  logic              start_i,
    input  logic              expire_i,
    input  logic [CNT_W-1:0]  meas_i,
    input  logic [CNT_W-1:0]  target_i,
    output logic              timer_run_o,
    output logic              timer_clr_o,
    output logic              settle_sel_o,
    output logic              meter_clr_o,
    output logic              meter_en_o,
    output logic [BAND_W-1:0] band_o,
    output logic              done_o,
    output logic              lf_clamp_o,
    output logic              cp_en_o
);
    localparam int IDX_W = (BAND_W > 1) ? $clog2(BAND_W) : 1;
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(BAND_W - 1);
    localparam logic [BAND_W-1:0] MSB_ONLY = {1'b1, {(BAND_W-1){1'b0}}};

    typedef struct packed {
        vbc_state_e        state;
        logic [BAND_W-1:0] band;
        logic [IDX_W-1:0]  idx;
        logic              done;
        logic              clamp;
        logic              cp_en;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      busy;
    logic      accept;

    always_comb begin
        busy   = (r_q.state == ST_SETTLE) || (r_q.state == ST_COUNT) ||
                 (r_q.state == ST_DECIDE);
        accept = start_i && cal_mode_i && !busy;

        r_d       = r_q;
        r_d.clamp = cal_mode_i;
        r_d.cp_en = !cal_mode_i;

        if (busy && !cal_mode_i) begin
            r_d.state = ST_IDLE;
            r_d.band  = '0;
            r_d.idx   = '0;
            r_d.done  = 1'b0;
        end else begin
            case (r_q.state)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        r_d.state = ST_SETTLE;
                        r_d.band  = MSB_ONLY;
                        r_d.idx   = TOP_IDX;
                        r_d.done  = 1'b0;
                    end
                end
                ST_SETTLE: begin
                    if (expire_i) r_d.state = ST_COUNT;
                end
                ST_COUNT: begin
                    if (expire_i) r_d.state = ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (meas_i >= target_i) r_d.band[r_q.idx] = 1'b0;
                    if (r_q.idx == '0) begin
                        r_d.state = ST_DONE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.idx                     = r_q.idx - 1'b1;
                        r_d.band[r_q.idx - 1'b1]    = 1'b1;
                        r_d.state                   = ST_SETTLE;
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.band  = '0;
                    r_d.idx   = '0;
                    r_d.done  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.band  <= '0;
            r_q.idx   <= '0;
            r_q.done  <= 1'b0;
            r_q.clamp <= 1'b0;
            r_q.cp_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign timer_run_o  = (r_q.state == ST_SETTLE) || (r_q.state == ST_COUNT);
    assign timer_clr_o  = !timer_run_o;
    assign settle_sel_o = (r_q.state == ST_SETTLE);
    assign meter_clr_o  = (r_q.state == ST_SETTLE);
    assign meter_en_o   = (r_q.state == ST_COUNT);
    assign band_o       = r_q.band;
    assign done_o       = r_q.done;
    assign lf_clamp_o   = r_q.clamp;
    assign cp_en_o      = r_q.cp_en;

    AST_CLAMP_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        cal_mode_i |=> (lf_clamp_o && !cp_en_o)); // R2

    AST_LOOP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_mode_i |=> (!lf_clamp_o && cp_en_o)); // R2

    AST_START_LOADS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (band_o == MSB_ONLY && !done_o)); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_mode_i && !busy) |=> ($stable(band_o) && $stable(done_o))); // R3

    AST_KEEP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DECIDE && cal_mode_i && meas_i < target_i)
        |=> band_o[$past(r_q.idx)]); // R4

    AST_DROP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DECIDE && cal_mode_i && meas_i >= target_i)
        |=> !band_o[$past(r_q.idx)]); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(start_i && cal_mode_i)) |=> (done_o && $stable(band_o))); // R7

    AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cal_mode_i) |=> (!done_o && band_o == '0)); // R8

    AST_DONE_ONLY_IDLE_OR_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(r_q.state == ST_DECIDE)); // R7

endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import vbc_pkg::*;
#(
    parameter int BAND_W       = 4,
    parameter int CNT_W        = 12,
    parameter int WIN_TICKS    = 1024,
    parameter int SETTLE_TICKS = 32,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_mode_i,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  target_i,
    input  logic              ref_tick_i,
    input  logic              vco_div_i,
    output logic [BAND_W-1:0] band_o,
    output logic              done_o,
    output logic              cp_en_o,
    output logic              lf_clamp_o
);
    localparam int TMR_W = $clog2(vbc_max(WIN_TICKS, SETTLE_TICKS) + 1);
    localparam logic [TMR_W-1:0] WIN_LIM    = TMR_W'(WIN_TICKS);
    localparam logic [TMR_W-1:0] SETTLE_LIM = TMR_W'(SETTLE_TICKS);

    logic             vco_rise;
    logic             timer_run, timer_clr, settle_sel, expire;
    logic             meter_clr, meter_en;
    logic [CNT_W-1:0] meas;
    logic [TMR_W-1:0] limit;

    assign limit = settle_sel ? SETTLE_LIM : WIN_LIM;

    vbc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (vco_div_i),
        .rise_o  (vco_rise)
    );

    vbc_tick_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (timer_clr),
        .run_i    (timer_run),
        .tick_i   (ref_tick_i),
        .limit_i  (limit),
        .expire_o (expire)
    );

    vbc_edge_counter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (meter_clr),
        .en_i    (meter_en),
        .pulse_i (vco_rise),
        .count_o (meas)
    );

    vbc_seq #(.BAND_W(BAND_W), .CNT_W(CNT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cal_mode_i   (cal_mode_i),
        .start_i      (start_i),
        .expire_i     (expire),
        .meas_i       (meas),
        .target_i     (target_i),
        .timer_run_o  (timer_run),
        .timer_clr_o  (timer_clr),
        .settle_sel_o (settle_sel),
        .meter_clr_o  (meter_clr),
        .meter_en_o   (meter_en),
        .band_o       (band_o),
        .done_o       (done_o),
        .lf_clamp_o   (lf_clamp_o),
        .cp_en_o      (cp_en_o)
    );

endmodule

// File: tb/sim_vco_band_cal.sv
module sim_vco_band_cal;
    localparam int BW   = 4;
    localparam int CW   = 8;
    localparam int WIN  = 256;
    localparam int SET  = 16;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cal_mode = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] target = '0;
    logic          ref_tick = 1'b0;
    logic          vco_div = 1'b0;
    logic [BW-1:0] band;
    logic          done, cp_en, lf_clamp;

    int  checks = 0;
    int  errors = 0;
    bit  fast = 1'b0;
    bit  ref_en = 1'b1;
    bit  mon_en = 1'b0;
    logic cal_seen = 1'b0;
    logic start_seen = 1'b0;
    logic prev_done = 1'b0;
    logic [BW-1:0] prev_band = '0;
    logic [5:0] acc = '0;

    always #10 clk = ~clk;

    vco_band_cal #(.BAND_W(BW), .CNT_W(CW), .WIN_TICKS(WIN),
                   .SETTLE_TICKS(SET), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_mode_i(cal_mode), .start_i(start),
        .target_i(target), .ref_tick_i(ref_tick), .vco_div_i(vco_div),
        .band_o(band), .done_o(done), .cp_en_o(cp_en), .lf_clamp_o(lf_clamp)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural oscillator: count per window = rate*(band+1), saturated.
    function automatic int osc_count(input int b, input bit f);
        int c;
        c = (f ? 16 : 8) * (b + 1);
        return (c > CMAX) ? CMAX : c;
    endfunction

    function automatic int model_band(input int tgt, input bit f);
        int b;
        b = 0;
        for (int i = BW - 1; i >= 0; i--) begin
            if (osc_count(b | (1 << i), f) < tgt) b = b | (1 << i);
        end
        return b;
    endfunction

    // Plant: oscillator and reference tick
    initial begin
        forever begin
            @(negedge clk);
            acc      = acc + 6'((fast ? 2 : 1) * (int'(band) + 1));
            vco_div  = acc[5];
            ref_tick = ref_en ? ~ref_tick : 1'b0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_seen   <= 1'b0;
            start_seen <= 1'b0;
        end else begin
            cal_seen   <= cal_mode;
            start_seen <= start && cal_mode;
        end
    end

    // Per-clock comparison against the reference model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mon_en) begin
                chk(lf_clamp == cal_seen && cp_en == !cal_seen, "R2 clamp/cp_en",
                    {lf_clamp, cp_en}, {cal_seen, !cal_seen});
                if (prev_done && !start_seen)
                    chk(done && band == prev_band, "R7 result hold",
                        {done, band}, {1'b1, prev_band});
                prev_done = done;
                prev_band = band;
            end
        end
    end

    task automatic wait_done(input string req, input int limit);
        int n;
        n = 0;
        while (!done && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, int'(done), 1);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_cal(input int tgt, input bit f, input string req);
        int exp;
        fast   = f;
        target = CW'(tgt);
        exp    = model_band(tgt, f);
        pulse_start();
        chk(band == 4'b1000 && !done, "R3 start loads MSB", {done, band}, 8);
        wait_done({req, " done"}, 20000);
        chk(int'(band) == exp, req, int'(band), exp);
    endtask

    initial begin
        int b0;
        repeat (3) @(negedge clk);
        chk(band == 0 && !done && !lf_clamp && cp_en, "R1 reset state",
            {band, done, lf_clamp, cp_en}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;

        // R3: start ignored while calibration mode is low
        pulse_start();
        repeat (3000) @(negedge clk);
        chk(!done && band == 0, "R3 start without cal ignored", {done, band}, 0);

        cal_mode = 1'b1;
        repeat (4) @(negedge clk);

        // R4: mid-gap targets, normal-rate oscillator
        run_cal(36, 1'b0, "R4 target 36");
        run_cal(84, 1'b0, "R4 target 84");
        run_cal(108, 1'b0, "R4 target 108");
        // R9: extremes
        run_cal(0, 1'b0, "R9 zero target");
        run_cal(CMAX, 1'b0, "R9 max target");
        // R6: saturation at top band (wrap would give 15)
        run_cal(CMAX, 1'b1, "R6 saturating count");
        run_cal(100, 1'b1, "R4 fast target 100");

        // R7: clearing cal mode after done keeps result
        b0 = int'(band);
        cal_mode = 1'b0;
        repeat (200) @(negedge clk);
        chk(done && int'(band) == b0, "R7 hold after cal cleared", int'(band), b0);
        cal_mode = 1'b1;
        repeat (4) @(negedge clk);

        // R3: start during search ignored
        fast = 1'b0;
        target = 8'd60;
        pulse_start();
        repeat (1500) @(negedge clk);
        b0 = int'(band);
        pulse_start();
        chk(int'(band) == b0 && !done, "R3 start during search ignored", int'(band), b0);
        wait_done("R3 search completes", 20000);
        chk(int'(band) == model_band(60, 1'b0), "R3 result after ignored start",
            int'(band), model_band(60, 1'b0));

        // R5: no ref ticks -> no progress
        target = 8'd36;
        pulse_start();
        repeat (800) @(negedge clk);
        ref_en = 1'b0;
        b0 = int'(band);
        repeat (3000) @(negedge clk);
        chk(int'(band) == b0 && !done, "R5 stalled without ref tick", int'(band), b0);
        ref_en = 1'b1;
        wait_done("R5 resumes", 20000);
        chk(int'(band) == model_band(36, 1'b0), "R5 result after stall",
            int'(band), model_band(36, 1'b0));

        // R8: abort mid search
        target = 8'd84;
        pulse_start();
        repeat (700) @(negedge clk);
        cal_mode = 1'b0;
        repeat (2) @(negedge clk);
        chk(!done && band == 0, "R8 abort clears", {done, band}, 0);
        cal_mode = 1'b1;
        repeat (4000) @(negedge clk);
        chk(!done && band == 0, "R8 no done without new start", {done, band}, 0);
        run_cal(84, 1'b0, "R8 restart after abort");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule